// File: doc/BRIEF.md
# Relaxed-Order Store Buffer with Load Hazard Tracking

This block holds committed stores between the load/store issue stage and a single memory write port. Stores leave in the order they arrived, one per cycle, and are free to reach memory before loads that were issued earlier and have not yet returned. Two things hold a store back. The first is a matching load: an outstanding load to the same word, issued before the store, keeps that store at the head of the queue until the load completes. The second is an ordering barrier: a store issued after a barrier waits until every load issued before that barrier has completed.

Each accepted load takes a slot in a small tracker and receives that slot's index, which it later returns on the completion port. Every store, load and barrier takes an age stamp from one shared sequence counter, and all "older than" decisions compare these stamps. When a newly accepted load reads a word that a held store still owns, the block raises a read-after-write flag in the same cycle. It does not forward any data.

Top module: `stbuf_war_top`

## Requirements
- R1: After reset the buffer and tracker are empty and no barrier is pending: `mw_valid` is 0, `st_ready` is 1, `ld_ready` is 1 and `ld_idx` is 0.
- R2: Stores are presented on the write port in arrival order. One store leaves per cycle that has `mw_valid` and `mw_ready` both high. The head entry is freed on that cycle. While `mw_valid` is high and `mw_ready` is low, `mw_addr` and `mw_data` hold steady.
- R3: A store whose word address matches no older outstanding load drains even while older loads to other words are outstanding. A load issued after the store, even to the same word, does not hold it.
- R4: While an outstanding load issued before the head store targets the same word, `mw_valid` stays 0. Every store behind the head waits as well.
- R5: `cmp_valid` with `cmp_idx` frees that tracker slot on the same clock edge. A store held only by that load shows `mw_valid`=1 in the cycle after the completion cycle, and not during it.
- R6: A store accepted after a barrier does not drain until every load accepted before the barrier has completed. Loads accepted after the barrier do not hold it, and stores accepted before the barrier are unaffected. Within one cycle the order of age is: load first, then barrier, then store. When barriers overlap, the stores held by the first barrier wait for the loads that precede the latest barrier.
- R7: With 8 stores held, `st_ready` is 0 and a store offered on `st_valid` is not taken.
- R8: With 4 loads outstanding, `ld_ready` is 0. Otherwise `ld_idx` shows the lowest-numbered free slot, and a load accepted in that cycle takes that slot.
- R9: `ld_raw` is 1 in a cycle with an accepted load whose word address matches a store still held, including a store that drains in that same cycle. A store accepted in the same cycle as the load does not count.
- R10: All address comparisons use bits 31:2 only. Bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| ld_valid | input | 1 | Load issued |
| ld_ready | output | 1 | Tracker has a free slot |
| ld_addr | input | 32 | Load byte address |
| ld_idx | output | 2 | Slot given to the load accepted this cycle |
| ld_raw | output | 1 | Accepted load matches a held store |
| cmp_valid | input | 1 | A load has completed |
| cmp_idx | input | 2 | Tracker slot of the completed load |
| bar_valid | input | 1 | Ordering barrier issued |
| mw_valid | output | 1 | Head store offered to memory |
| mw_ready | input | 1 | Memory takes the offered store |
| mw_addr | output | 32 | Address of the offered store |
| mw_data | output | 32 | Data of the offered store |

## Verification
The bound checker watches, on every cycle, the properties that need no knowledge of age: the write port holds steady while it is stalled, it is silent when the queue is empty, both stall outputs follow occupancy, a completion clears its slot, and the hazard flag only appears with an accepted load. Whether the right store is held, whether it is released exactly one cycle after its load completes, and how barriers order stores within a cycle and across overlapping barriers depend on age stamps. Only the bench's sweeps show these: they sweep the matching slot and the byte offset, overlap barriers, and issue a load, a barrier and a store in the same cycle.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  localparam int SEQ_W = 8;
  typedef logic [SEQ_W-1:0] seq_t;

  // True when stamp a was issued before stamp b (modular distance).
  function automatic logic seq_older(seq_t a, seq_t b);
    seq_t diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  seq_t          push_seq,
  input  logic          pop,
  input  logic [AW-1:0] probe_addr,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output seq_t          head_seq,
  output logic          probe_hit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  seq_t             seq_q  [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = pop  ? ptr_inc(rd_q) : rd_q;
    wr_d  = push ? ptr_inc(wr_q) : wr_q;
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
    vld_d = vld_q;
    if (pop)  vld_d[rd_q] = 1'b0;
    if (push) vld_d[wr_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wen;
    assign wen = push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (wen) begin
        addr_q[g] <= push_addr;
        data_q[g] <= push_data;
        seq_q[g]  <= push_seq;
      end
    end
  end

  always_comb begin
    probe_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && (addr_q[i][AW-1:2] == probe_addr[AW-1:2])) probe_hit = 1'b1;
    end
  end

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = addr_q[rd_q];
  assign head_data = data_q[rd_q];
  assign head_seq  = seq_q[rd_q];
endmodule

// File: rtl/ld_tracker.sv
module ld_tracker
  import stbuf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int AW      = 32,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [AW-1:0]    alloc_addr,
  input  seq_t             alloc_seq,
  input  logic             free_en,
  input  logic [IDX_W-1:0] free_idx,
  input  logic [AW-1:0]    q_addr,
  input  seq_t             q_seq,
  input  seq_t             bar_seq,
  output logic             has_free,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             war_hit,
  output logic             bar_old
);
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [AW-1:0]      addr_q [ENTRIES];
  seq_t               seq_q  [ENTRIES];

  always_comb begin
    alloc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) alloc_idx = IDX_W'(i);
    end
  end

  assign has_free = ~&vld_q;

  always_comb begin
    vld_d = vld_q;
    if (free_en && (int'(free_idx) < ENTRIES)) vld_d[free_idx] = 1'b0;
    if (alloc) vld_d[alloc_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wen;
    assign wen = alloc && (alloc_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wen) begin
        addr_q[g] <= alloc_addr;
        seq_q[g]  <= alloc_seq;
      end
    end
  end

  always_comb begin
    war_hit = 1'b0;
    bar_old = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && (addr_q[i][AW-1:2] == q_addr[AW-1:2]) && seq_older(seq_q[i], q_seq))
        war_hit = 1'b1;
      if (vld_q[i] && seq_older(seq_q[i], bar_seq))
        bar_old = 1'b1;
    end
  end
endmodule

// File: rtl/sb_order_ctl.sv
module sb_order_ctl
  import stbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_fire,
  input  logic bar_in,
  input  logic st_fire,
  input  logic bar_old,
  input  seq_t head_seq,
  output seq_t ld_seq,
  output seq_t st_seq,
  output seq_t bar_hi,
  output logic bar_block
);
  seq_t cnt_q, cnt_d;
  seq_t lo_q, lo_d, hi_q, hi_d;
  seq_t bar_stamp;
  logic pend_q, pend_d;

  always_comb begin
    ld_seq    = cnt_q;
    bar_stamp = cnt_q + seq_t'(ld_fire);
    st_seq    = bar_stamp + seq_t'(bar_in);
    cnt_d     = st_seq + seq_t'(st_fire);
    pend_d    = pend_q;
    lo_d      = lo_q;
    hi_d      = hi_q;
    if (bar_in) begin
      pend_d = 1'b1;
      hi_d   = bar_stamp;
      lo_d   = (pend_q && bar_old) ? lo_q : bar_stamp;
    end else if (pend_q && !bar_old) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      pend_q <= pend_d;
    end
  end

  assign bar_hi    = hi_q;
  assign bar_block = pend_q && bar_old && seq_older(lo_q, head_seq);
endmodule

// File: rtl/stbuf_war_top.sv
module stbuf_war_top
  import stbuf_pkg::*;
#(
  parameter int SB_DEPTH = 8,
  parameter int LT_DEPTH = 4,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int IDX_W    = $clog2(LT_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [AW-1:0]    st_addr,
  input  logic [DW-1:0]    st_data,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [AW-1:0]    ld_addr,
  output logic [IDX_W-1:0] ld_idx,
  output logic             ld_raw,
  input  logic             cmp_valid,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             bar_valid,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [AW-1:0]    mw_addr,
  output logic [DW-1:0]    mw_data
);
  logic st_fire, ld_fire, pop;
  logic sb_full, sb_empty, raw_hit, war_hit, bar_old, bar_block;
  seq_t ld_seq, st_seq, head_seq, bar_hi;

  assign st_ready = !sb_full;
  assign st_fire  = st_valid && !sb_full;
  assign ld_fire  = ld_valid && ld_ready;
  assign ld_raw   = ld_fire && raw_hit;
  assign mw_valid = !sb_empty && !war_hit && !bar_block;
  assign pop      = mw_valid && mw_ready;

  sb_fifo #(.DEPTH(SB_DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(st_fire), .push_addr(st_addr), .push_data(st_data), .push_seq(st_seq),
    .pop(pop), .probe_addr(ld_addr),
    .full(sb_full), .empty(sb_empty),
    .head_addr(mw_addr), .head_data(mw_data), .head_seq(head_seq),
    .probe_hit(raw_hit)
  );

  ld_tracker #(.ENTRIES(LT_DEPTH), .AW(AW), .IDX_W(IDX_W)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .alloc(ld_fire), .alloc_addr(ld_addr), .alloc_seq(ld_seq),
    .free_en(cmp_valid), .free_idx(cmp_idx),
    .q_addr(mw_addr), .q_seq(head_seq), .bar_seq(bar_hi),
    .has_free(ld_ready), .alloc_idx(ld_idx),
    .war_hit(war_hit), .bar_old(bar_old)
  );

  sb_order_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ld_fire(ld_fire), .bar_in(bar_valid), .st_fire(st_fire),
    .bar_old(bar_old), .head_seq(head_seq),
    .ld_seq(ld_seq), .st_seq(st_seq), .bar_hi(bar_hi),
    .bar_block(bar_block)
  );
endmodule

// File: rtl/stbuf_war_chk.sv
module stbuf_war_chk #(
  parameter int SB_DEPTH = 8,
  parameter int LT_DEPTH = 4,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int IDX_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                st_ready,
  input logic                ld_valid,
  input logic                ld_ready,
  input logic                ld_raw,
  input logic                cmp_valid,
  input logic [IDX_W-1:0]    cmp_idx,
  input logic                mw_valid,
  input logic                mw_ready,
  input logic [AW-1:0]       mw_addr,
  input logic [DW-1:0]       mw_data,
  input logic [SB_DEPTH-1:0] sb_vld,
  input logic [LT_DEPTH-1:0] lt_vld
);
  AST_MW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data)); // R2
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_vld == '0) |-> !mw_valid); // R1
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sb_vld) == SB_DEPTH) |-> !st_ready); // R7
  AST_CMP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && lt_vld[cmp_idx] |=> !lt_vld[$past(cmp_idx)]); // R5
  AST_TRK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lt_vld) == LT_DEPTH) |-> !ld_ready); // R8
  AST_RAW_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_raw |-> ld_valid && ld_ready); // R9
endmodule

bind stbuf_war_top stbuf_war_chk #(
  .SB_DEPTH(SB_DEPTH), .LT_DEPTH(LT_DEPTH), .AW(AW), .DW(DW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_raw(ld_raw),
  .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
  .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
  .sb_vld(u_fifo.vld_q), .lt_vld(u_trk.vld_q)
);

// File: tb/stbuf_war_top_tb.sv
module stbuf_war_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_ready;
  logic [31:0] st_addr, st_data;
  logic        ld_valid, ld_ready, ld_raw;
  logic [31:0] ld_addr;
  logic [1:0]  ld_idx;
  logic        cmp_valid;
  logic [1:0]  cmp_idx;
  logic        bar_valid;
  logic        mw_valid, mw_ready;
  logic [31:0] mw_addr, mw_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stbuf_war_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_idx(ld_idx), .ld_raw(ld_raw),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .bar_valid(bar_valid),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic load(input logic [31:0] a);
    ld_valid = 1'b1; ld_addr = a;
    tick();
    ld_valid = 1'b0;
  endtask

  task automatic finish_ld(input int i);
    cmp_valid = 1'b1; cmp_idx = 2'(i);
    tick();
    cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 0; st_addr = 0; st_data = 0;
    ld_valid = 0; ld_addr = 0; cmp_valid = 0; cmp_idx = 0;
    bar_valid = 0; mw_ready = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 mw_valid", 32'(mw_valid), 0);
    chk("R1 st_ready", 32'(st_ready), 1);
    chk("R1 ld_ready", 32'(ld_ready), 1);
    chk("R1 ld_idx",   32'(ld_idx), 0);

    // R7 fill to capacity, R2 stalled order and stability
    for (int n = 0; n < 8; n++) begin
      push(32'h100 + 32'(n) * 4, 32'hA000_0000 + 32'(n));
      settle();
      chk("R7 st_ready while filling", 32'(st_ready), 32'(n < 7));
    end
    push(32'h0FFC, 32'hDEAD);
    settle();
    chk("R7 head after refused push", mw_addr, 32'h100);
    for (int k = 0; k < 8; k++) begin
      mw_ready = 1'b0; settle();
      chk("R2 valid when stalled", 32'(mw_valid), 1);
      chk("R2 order addr", mw_addr, 32'h100 + 32'(k) * 4);
      tick();
      mw_ready = 1'b1; settle();
      chk("R2 held addr", mw_addr, 32'h100 + 32'(k) * 4);
      chk("R2 held data", mw_data, 32'hA000_0000 + 32'(k));
      tick();
    end
    settle();
    chk("R7 refused store absent", 32'(mw_valid), 0);
    chk("R7 ready after drain", 32'(st_ready), 1);

    // R2 back to back, one per cycle
    mw_ready = 1'b0;
    for (int n = 0; n < 4; n++) push(32'h180 + 32'(n) * 4, 32'hB0 + 32'(n));
    mw_ready = 1'b1;
    for (int n = 0; n < 4; n++) begin
      settle();
      chk("R2 one per cycle", mw_addr, 32'h180 + 32'(n) * 4);
      tick();
    end
    settle();
    chk("R2 empty after drain", 32'(mw_valid), 0);

    // R4 R5 R8 R10 sweep over matching slot and byte offset
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        mw_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
          ld_valid = 1'b1; ld_addr = 32'h200 + 32'(i) * 16;
          settle();
          chk("R8 lowest free slot", 32'(ld_idx), 32'(i));
          tick();
          ld_valid = 1'b0;
        end
        settle();
        chk("R8 tracker full", 32'(ld_ready), 0);
        push(32'h200 + 32'(k) * 16 + 32'(j), 32'h5000 + 32'(k));
        push(32'h300, 32'h6000);
        mw_ready = 1'b1;
        for (int c = 0; c < 3; c++) begin
          settle();
          chk("R4 R10 matched store held", 32'(mw_valid), 0);
          tick();
        end
        cmp_valid = 1'b1; cmp_idx = 2'(k);
        settle();
        chk("R5 held during completion cycle", 32'(mw_valid), 0);
        tick();
        cmp_valid = 1'b0;
        settle();
        chk("R5 released next cycle", 32'(mw_valid), 1);
        chk("R5 released addr", mw_addr, 32'h200 + 32'(k) * 16 + 32'(j));
        chk("R8 freed slot reused", 32'(ld_idx), 32'(k));
        tick();
        settle();
        chk("R4 follower in order", mw_addr, 32'h300);
        tick();
        settle();
        chk("R4 queue empty", 32'(mw_valid), 0);
        for (int i = 0; i < 4; i++) if (i != k) finish_ld(i);
      end
    end

    // R3 relaxed drain past older load
    mw_ready = 1'b1;
    load(32'h400);
    push(32'h404, 32'h44);
    settle();
    chk("R3 drains past older load", 32'(mw_valid), 1);
    chk("R3 addr", mw_addr, 32'h404);
    tick();
    mw_ready = 1'b0;
    push(32'h500, 32'h55);
    ld_valid = 1'b1; ld_addr = 32'h500;
    settle();
    chk("R9 raw flagged", 32'(ld_raw), 1);
    tick();
    ld_valid = 1'b0;
    mw_ready = 1'b1;
    settle();
    chk("R3 younger load does not hold", 32'(mw_valid), 1);
    chk("R3 addr 500", mw_addr, 32'h500);
    tick();
    finish_ld(0);
    finish_ld(1);

    // R6 barrier with older load
    load(32'h600);
    bar_valid = 1'b1; tick(); bar_valid = 1'b0;
    push(32'h700, 32'h77);
    for (int c = 0; c < 3; c++) begin
      settle();
      chk("R6 held by barrier", 32'(mw_valid), 0);
      tick();
    end
    finish_ld(0);
    settle();
    chk("R6 released", 32'(mw_valid), 1);
    chk("R6 addr", mw_addr, 32'h700);
    tick();

    // R6 loads after barrier do not hold
    bar_valid = 1'b1; tick(); bar_valid = 1'b0;
    load(32'h800);
    push(32'h900, 32'h99);
    settle();
    chk("R6 later load no hold", 32'(mw_valid), 1);
    tick();
    finish_ld(0);

    // R6 same-cycle load, barrier, store
    ld_valid = 1'b1; ld_addr = 32'hA00; bar_valid = 1'b1;
    st_valid = 1'b1; st_addr = 32'hB00; st_data = 32'hBB;
    tick();
    ld_valid = 1'b0; bar_valid = 1'b0; st_valid = 1'b0;
    for (int c = 0; c < 2; c++) begin
      settle();
      chk("R6 same-cycle order held", 32'(mw_valid), 0);
      tick();
    end
    finish_ld(0);
    settle();
    chk("R6 same-cycle released", mw_addr, 32'hB00);
    chk("R6 same-cycle valid", 32'(mw_valid), 1);
    tick();

    // R6 store before barrier unaffected
    mw_ready = 1'b0;
    push(32'hC00, 32'hCC);
    load(32'hD00);
    bar_valid = 1'b1; tick(); bar_valid = 1'b0;
    mw_ready = 1'b1;
    settle();
    chk("R6 older store free", 32'(mw_valid), 1);
    chk("R6 older store addr", mw_addr, 32'hC00);
    tick();
    finish_ld(0);

    // R6 overlapping barriers
    load(32'h1000);
    bar_valid = 1'b1; tick(); bar_valid = 1'b0;
    load(32'h1100);
    bar_valid = 1'b1; tick(); bar_valid = 1'b0;
    push(32'h1200, 32'h12);
    finish_ld(0);
    settle();
    chk("R6 second barrier still holds", 32'(mw_valid), 0);
    finish_ld(1);
    settle();
    chk("R6 overlap released", 32'(mw_valid), 1);
    chk("R6 overlap addr", mw_addr, 32'h1200);
    tick();

    // R9 R10 raw flag sweep (loads not clocked in)
    mw_ready = 1'b0;
    push(32'hE00, 32'hEE);
    for (int off = 0; off < 4; off++) begin
      ld_valid = 1'b1; ld_addr = 32'hE00 + 32'(off);
      settle();
      chk("R9 R10 raw on offset", 32'(ld_raw), 1);
    end
    ld_addr = 32'hE04;
    settle();
    chk("R9 other word no raw", 32'(ld_raw), 0);
    ld_valid = 1'b0;
    settle();
    chk("R9 no load no raw", 32'(ld_raw), 0);
    ld_valid = 1'b1; ld_addr = 32'hF00;
    st_valid = 1'b1; st_addr = 32'hF00; st_data = 32'hFF;
    settle();
    chk("R9 same-cycle store not counted", 32'(ld_raw), 0);
    tick();
    ld_valid = 1'b0; st_valid = 1'b0;
    mw_ready = 1'b1;
    ld_valid = 1'b1; ld_addr = 32'hE00;
    settle();
    chk("R9 raw on draining store", 32'(ld_raw), 1);
    chk("R2 draining head", mw_addr, 32'hE00);
    ld_valid = 1'b0;
    tick();
    settle();
    chk("R4 store behind same-cycle load held", 32'(mw_valid), 0);
    finish_ld(0);
    settle();
    chk("R5 F00 released", mw_addr, 32'hF00);
    chk("R5 F00 valid", 32'(mw_valid), 1);
    tick();
    settle();
    chk("R2 drained all", 32'(mw_valid), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule